// File: doc/BRIEF.md
# Sectioned Control Register Access Controller

This block sits behind the serial slave of a clock chip and turns decoded bus events into accesses to a 64-byte control space. The upstream bit engine reports start, the device byte, master-written bytes, master read requests and stop, one event per cycle at most. The block decides whether it is selected, keeps the address pointer, stages write data, and commits the staged data only when stop arrives. It also serves read bytes. Clock-section reads come from a snapshot taken when the read begins.

The space holds five sections. Sequential accesses wrap inside the section where they started. The single status byte ends an operation after one byte. Writes outside the status byte need two enable bits in the status byte. Writes to the clock section go out to the external time counter as a one-cycle load pulse with a byte mask. The alarm and control bytes are held inside the block.

Top module: `ccr_access`

## Requirements
- R1: The block responds only after a start followed by a device byte whose bits [7:1] equal 1101111, and bit 0 selects read (1) or write (0). After any other device byte, written bytes change nothing and read requests produce no `rd_valid` until the next start.
- R2: The sections sit at fixed addresses: first alarm 0x00–0x07, second alarm 0x08–0x0F, control 0x10–0x13, clock 0x30–0x37 and status 0x3F. A sequential read or write past the last byte of a section continues at the first byte of the same section.
- R3: In a write, the first byte after the device byte sets the pointer from its bits [5:0], and the pointer may name any address. Each data byte or read byte moves the pointer to the next address under R2. A later read that begins with no address byte continues from that pointer.
- R4: In the status byte, only one data byte per operation is taken. Further written bytes are ignored, and further read requests produce no `rd_valid`.
- R5: At stop, staged bytes outside the status byte are committed only if status bit 1 and status bit 2 were both already set before that stop. Otherwise those bytes are dropped and nothing changes.
- R6: The status byte can always be written. Only its bits 1 and 2 are stored, and its other bits read as 0.
- R7: Written bytes take effect only at stop. A repeated start discards the bytes staged before it. Clock-section bytes that are committed appear on `tm_wdata` (byte k at bits [8k+7:8k] for address 0x30+k), with `tm_wmask` bit k set and `tm_load` high for the one cycle after stop.
- R8: A read device byte copies `time_live` into a snapshot. Clock-section reads return that snapshot, so later changes of `time_live` do not show until the next read begins.
- R9: Undefined addresses read as 0 and ignore writes. From an undefined address the pointer steps by plain +1, so 0x2F is followed by 0x30.
- R10: After reset the stored bytes, the status byte, the snapshot and the pointer are 0, and `rd_valid` and `tm_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_devsel | input | 1 | Device byte received on `bus_byte` |
| ev_byte_wr | input | 1 | Master-written byte on `bus_byte` |
| ev_byte_rd | input | 1 | Master requests a read byte |
| ev_stop | input | 1 | Stop seen |
| bus_byte | input | 8 | Byte for device and write events |
| time_live | input | 64 | Live clock-section bytes from the time counter |
| rd_byte | output | 8 | Byte returned for the last read request |
| rd_valid | output | 1 | One-cycle pulse: `rd_byte` is fresh |
| tm_load | output | 1 | One-cycle pulse: commit clock-section bytes |
| tm_wdata | output | 64 | Committed clock-section bytes |
| tm_wmask | output | 8 | Which clock-section bytes to load |

## Verification
The assertions assume that at most one bus event is raised in any cycle and that a device byte is reported only right after a start. The upstream bit engine guarantees both. The bench drives every event as a single-cycle pulse on the falling edge, one event at a time, and always sends a start before each device byte. Given those assumptions, the properties check four things: the pointer stays in its section as it advances, stored status and snapshot bytes move only on commit or read start, a locked commit never loads the counter, and a read request in the status byte after its one byte gets no answer.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int ADDR_W     = 6;
    localparam int NBYTES     = 1 << ADDR_W;
    localparam int BYTE_W     = 8;
    localparam int TIME_BYTES = 8;
    localparam int TIME_W     = TIME_BYTES * BYTE_W;

    localparam logic [6:0] DEV_ID_DEF = 7'b1101111;

    localparam logic [ADDR_W-1:0] TIME_BASE = 6'h30;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 6'h3F;

    localparam int WEN_BIT  = 1;
    localparam int RWEN_BIT = 2;
    localparam logic [BYTE_W-1:0] STAT_WMASK = 8'h06;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        SEC_ALM_A, SEC_ALM_B, SEC_CTRL, SEC_TIME, SEC_STAT, SEC_NONE
    } sec_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_DEV, PH_ADDR, PH_WDATA, PH_RDATA, PH_END
    } phase_e;

    function automatic sec_e sec_of(input addr_t a);
        if (a[5:3] == 3'b000)      return SEC_ALM_A;
        else if (a[5:3] == 3'b001) return SEC_ALM_B;
        else if (a[5:2] == 4'b0100) return SEC_CTRL;
        else if (a[5:3] == 3'b110) return SEC_TIME;
        else if (a == STAT_ADDR)   return SEC_STAT;
        else                       return SEC_NONE;
    endfunction

    // Next address with wraparound confined to the section.
    function automatic addr_t next_addr(input addr_t a);
        case (sec_of(a))
            SEC_ALM_A, SEC_ALM_B, SEC_TIME: return {a[5:3], a[2:0] + 3'd1};
            SEC_CTRL:                       return {a[5:2], a[1:0] + 2'd1};
            SEC_STAT:                       return a;
            default:                        return a + addr_t'(1);
        endcase
    endfunction

endpackage

// File: rtl/ccr_ptr.sv
module ccr_ptr
    import ccr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t load_addr,
    input  logic  adv,
    output addr_t ptr
);

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_addr;
        else if (adv)  ptr <= next_addr(ptr);
    end

    // R2
    sect_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && sec_of(ptr) != SEC_NONE) |=> sec_of(ptr) == $past(sec_of(ptr)));

endmodule

// File: rtl/ccr_stage.sv
module ccr_stage
    import ccr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    wr_en,
    input  addr_t                   wr_addr,
    input  byte_t                   wr_data,
    output logic [NBYTES-1:0][BYTE_W-1:0] stg_data,
    output logic [NBYTES-1:0]       stg_mask
);

    for (genvar i = 0; i < NBYTES; i++) begin : g_slot
        localparam sec_e S = sec_of(addr_t'(i));
        if (S != SEC_NONE) begin : g_live
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    stg_mask[i] <= 1'b0;
                    stg_data[i] <= '0;
                end else if (wr_en && wr_addr == addr_t'(i)) begin
                    stg_mask[i] <= 1'b1;
                    stg_data[i] <= wr_data;
                end
            end
        end else begin : g_hole
            assign stg_mask[i] = 1'b0;
            assign stg_data[i] = '0;
        end
    end

endmodule

// File: rtl/ccr_store.sv
module ccr_store
    import ccr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    commit,
    input  logic                    snap_en,
    input  logic [TIME_W-1:0]       time_live,
    input  logic [NBYTES-1:0][BYTE_W-1:0] stg_data,
    input  logic [NBYTES-1:0]       stg_mask,
    input  addr_t                   rd_addr,
    output byte_t                   rd_data,
    output logic                    tm_load,
    output logic [TIME_W-1:0]       tm_wdata,
    output logic [TIME_BYTES-1:0]   tm_wmask
);

    logic [NBYTES-1:0][BYTE_W-1:0] view;
    logic [TIME_W-1:0]             snap_v;
    logic [TIME_W-1:0]             tdata_d;
    logic [TIME_BYTES-1:0]         tmask_d;
    byte_t                         stat_q;
    logic                          prot_ok;

    assign prot_ok = stat_q[WEN_BIT] & stat_q[RWEN_BIT];

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam sec_e S = sec_of(addr_t'(i));
        if (S == SEC_ALM_A || S == SEC_ALM_B || S == SEC_CTRL) begin : g_reg
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst)                              q <= '0;
                else if (commit && prot_ok && stg_mask[i]) q <= stg_data[i];
            end
            assign view[i] = q;
        end else if (S == SEC_TIME) begin : g_time
            localparam int K = i - int'(TIME_BASE);
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst)          q <= '0;
                else if (snap_en) q <= time_live[K*BYTE_W +: BYTE_W];
            end
            assign view[i]                  = q;
            assign snap_v[K*BYTE_W +: BYTE_W] = q;
            assign tdata_d[K*BYTE_W +: BYTE_W] = stg_data[i];
            assign tmask_d[K]               = stg_mask[i];
        end else if (S == SEC_STAT) begin : g_stat
            always_ff @(posedge clk) begin
                if (rst)                         stat_q <= '0;
                else if (commit && stg_mask[i])  stat_q <= stg_data[i] & STAT_WMASK;
            end
            assign view[i] = stat_q;
        end else begin : g_hole
            logic unused_hole;
            assign unused_hole = ^{stg_data[i], stg_mask[i]};
            assign view[i]     = '0;
        end
    end

    assign rd_data = view[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_load  <= 1'b0;
            tm_wdata <= '0;
            tm_wmask <= '0;
        end else begin
            tm_load <= commit && prot_ok && (|tmask_d);
            if (commit && prot_ok) begin
                tm_wdata <= tdata_d;
                tm_wmask <= tmask_d;
            end
        end
    end

    // R5
    locked_noload_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !prot_ok) |=> !tm_load);

    // R6
    stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(stat_q));

    // R8
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !snap_en |=> $stable(snap_v));

endmodule

// File: rtl/ccr_access.sv
module ccr_access
    import ccr_pkg::*;
#(
    parameter logic [6:0] DEV_ID = DEV_ID_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ev_start,
    input  logic                  ev_devsel,
    input  logic                  ev_byte_wr,
    input  logic                  ev_byte_rd,
    input  logic                  ev_stop,
    input  logic [7:0]            bus_byte,
    input  logic [TIME_W-1:0]     time_live,
    output logic [7:0]            rd_byte,
    output logic                  rd_valid,
    output logic                  tm_load,
    output logic [TIME_W-1:0]     tm_wdata,
    output logic [TIME_BYTES-1:0] tm_wmask
);

    phase_e phase;
    addr_t  ptr;
    byte_t  rdata;
    logic   dev_hit, snap_en, ptr_load, stg_wr, rd_go, adv, stg_clr;
    logic [NBYTES-1:0][BYTE_W-1:0] stg_data;
    logic [NBYTES-1:0]             stg_mask;

    assign dev_hit  = ev_devsel && phase == PH_DEV && bus_byte[7:1] == DEV_ID;
    assign snap_en  = dev_hit && bus_byte[0];
    assign ptr_load = ev_byte_wr && phase == PH_ADDR;
    assign stg_wr   = ev_byte_wr && phase == PH_WDATA;
    assign rd_go    = ev_byte_rd && phase == PH_RDATA;
    assign adv      = stg_wr || rd_go;
    assign stg_clr  = ev_start || ev_stop;

    always_ff @(posedge clk) begin
        if (rst || ev_stop) begin
            phase <= PH_IDLE;
        end else if (ev_start) begin
            phase <= PH_DEV;
        end else if (ev_devsel && phase == PH_DEV) begin
            if (!dev_hit)         phase <= PH_IDLE;
            else if (bus_byte[0]) phase <= PH_RDATA;
            else                  phase <= PH_ADDR;
        end else if (ptr_load) begin
            phase <= PH_WDATA;
        end else if (adv && sec_of(ptr) == SEC_STAT) begin
            phase <= PH_END;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_byte  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) rd_byte <= rdata;
        end
    end

    ccr_ptr u_ptr (
        .clk(clk), .rst(rst), .load(ptr_load), .load_addr(bus_byte[ADDR_W-1:0]),
        .adv(adv), .ptr(ptr)
    );

    ccr_stage u_stage (
        .clk(clk), .rst(rst), .clr(stg_clr), .wr_en(stg_wr), .wr_addr(ptr),
        .wr_data(bus_byte), .stg_data(stg_data), .stg_mask(stg_mask)
    );

    ccr_store u_store (
        .clk(clk), .rst(rst), .commit(ev_stop), .snap_en(snap_en),
        .time_live(time_live), .stg_data(stg_data), .stg_mask(stg_mask),
        .rd_addr(ptr), .rd_data(rdata), .tm_load(tm_load),
        .tm_wdata(tm_wdata), .tm_wmask(tm_wmask)
    );

    // R1
    ev_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_start, ev_devsel, ev_byte_wr, ev_byte_rd, ev_stop}));

    // R3
    rd_src_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(ev_byte_rd));

    // R4
    stat_end_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_END && ev_byte_rd) |=> !rd_valid);

endmodule

// File: tb/ccr_access_test.sv
module ccr_access_test;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_start = 0, ev_devsel = 0, ev_byte_wr = 0, ev_byte_rd = 0, ev_stop = 0;
    logic [7:0]  bus_byte = '0;
    logic [63:0] time_live = '0;
    logic [7:0]  rd_byte;
    logic        rd_valid;
    logic        tm_load;
    logic [63:0] tm_wdata;
    logic [7:0]  tm_wmask;

    int checks = 0;
    int errors = 0;
    logic        s_valid, s_load;
    logic [7:0]  s_byte, s_mask;
    logic [63:0] s_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccr_access uut (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_devsel(ev_devsel),
        .ev_byte_wr(ev_byte_wr), .ev_byte_rd(ev_byte_rd), .ev_stop(ev_stop),
        .bus_byte(bus_byte), .time_live(time_live), .rd_byte(rd_byte),
        .rd_valid(rd_valid), .tm_load(tm_load), .tm_wdata(tm_wdata), .tm_wmask(tm_wmask)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // kind: 0 start, 1 device, 2 write byte, 3 read byte, 4 stop
    task automatic pulse(input int kind, input logic [7:0] b);
        @(negedge clk);
        bus_byte   = b;
        ev_start   = (kind == 0);
        ev_devsel  = (kind == 1);
        ev_byte_wr = (kind == 2);
        ev_byte_rd = (kind == 3);
        ev_stop    = (kind == 4);
        @(negedge clk);
        {ev_start, ev_devsel, ev_byte_wr, ev_byte_rd, ev_stop} = '0;
        s_valid = rd_valid; s_byte = rd_byte;
        s_load = tm_load; s_mask = tm_wmask; s_wdata = tm_wdata;
    endtask

    task automatic dev(input logic [7:0] d);  pulse(0, 8'h00); pulse(1, d); endtask
    task automatic wr(input logic [7:0] b);   pulse(2, b); endtask
    task automatic rd();                      pulse(3, 8'h00); endtask
    task automatic stop();                    pulse(4, 8'h00); endtask
    task automatic set_ptr(input logic [7:0] a); dev(8'hDE); wr(a); endtask
    task automatic rd_at(input logic [7:0] a);   set_ptr(a); dev(8'hDF); rd(); endtask

    task automatic t_reset();
        check("R10 rd_valid", rd_valid, 0);
        check("R10 tm_load", tm_load, 0);
        rd_at(8'h3F); check("R10 status", s_byte, 0);
        stop();
        rd_at(8'h30); check("R10 snapshot", s_byte, 0);
        stop();
    endtask

    task automatic t_locked();
        set_ptr(8'h02); wr(8'hAA); stop();
        rd_at(8'h02); check("R5 locked alarm", s_byte, 0); stop();
        set_ptr(8'h30); wr(8'h12); stop();
        check("R5 locked time load", s_load, 0);
    endtask

    task automatic t_bad_dev();
        dev(8'h06); wr(8'h3F); wr(8'h06); stop();
        rd_at(8'h3F); check("R1 bad dev write", s_byte, 0); stop();
        dev(8'hDD); rd(); check("R1 bad dev read", s_valid, 0); stop();
        dev(8'h9F); rd(); check("R1 wrong id", s_valid, 0); stop();
    endtask

    task automatic t_unlock();
        set_ptr(8'h3F); wr(8'hFF); stop();
        rd_at(8'h3F); check("R6 status bits", s_byte, 8'h06); stop();
    endtask

    task automatic t_alarm_wrap();
        set_ptr(8'h0E); wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44); stop();
        rd_at(8'h0E); check("R3 start mid", s_byte, 8'h11);
        rd(); check("R2 0F", s_byte, 8'h22);
        rd(); check("R2 wrap to 08", s_byte, 8'h33);
        stop();
        dev(8'hDF); rd(); check("R3 current addr", s_byte, 8'h44); stop();
        rd_at(8'h07); check("R2 no spill", s_byte, 0); stop();
    endtask

    task automatic t_ctrl_wrap();
        set_ptr(8'h13); wr(8'hA1); wr(8'hA2); stop();
        rd_at(8'h10); check("R2 ctrl wrap write", s_byte, 8'hA2);
        rd(); check("R2 ctrl 11", s_byte, 0); stop();
        rd_at(8'h13); check("R2 ctrl 13", s_byte, 8'hA1);
        rd(); check("R2 ctrl read wrap", s_byte, 8'hA2); stop();
    endtask

    task automatic t_time_write();
        set_ptr(8'h36); wr(8'h66); wr(8'h77);
        check("R7 no load before stop", tm_load, 0);
        wr(8'h88); stop();
        check("R7 load", s_load, 1);
        check("R7 mask", s_mask, 8'hC1);
        check("R7 byte6", s_wdata[55:48], 8'h66);
        check("R7 byte7", s_wdata[63:56], 8'h77);
        check("R7 byte0", s_wdata[7:0], 8'h88);
        @(negedge clk); check("R7 one cycle", tm_load, 0);
    endtask

    task automatic t_restart();
        set_ptr(8'h00); wr(8'h55); dev(8'hDE); stop();
        rd_at(8'h00); check("R7 restart discard", s_byte, 0); stop();
    endtask

    task automatic t_status_end();
        set_ptr(8'h3F); wr(8'h06); wr(8'h00); stop();
        rd_at(8'h3F); check("R4 second write ignored", s_byte, 8'h06);
        check("R4 first read", s_valid, 1);
        rd(); check("R4 second read", s_valid, 0); stop();
    endtask

    task automatic t_snapshot();
        time_live = 64'h8877_6655_4433_2211;
        rd_at(8'h37); check("R8 first", s_byte, 8'h88);
        time_live = '1;
        rd(); check("R8 frozen wrap", s_byte, 8'h11);
        rd(); check("R8 frozen", s_byte, 8'h22); stop();
        rd_at(8'h30); check("R8 new snapshot", s_byte, 8'hFF); stop();
    endtask

    task automatic t_undef();
        set_ptr(8'h20); wr(8'h99); stop();
        rd_at(8'h20); check("R9 undef read", s_byte, 0);
        check("R9 undef valid", s_valid, 1); stop();
        set_ptr(8'h2F); wr(8'h44); wr(8'h55); stop();
        check("R9 step load", s_load, 1);
        check("R9 step mask", s_mask, 8'h01);
        check("R9 step data", s_wdata[7:0], 8'h55);
    endtask

    task automatic t_relock();
        set_ptr(8'h3F); wr(8'h02); stop();
        set_ptr(8'h05); wr(8'h77); stop();
        rd_at(8'h05); check("R5 half unlock", s_byte, 0); stop();
        rd_at(8'h0E); check("R5 old data kept", s_byte, 8'h11); stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_locked();
        t_bad_dev();
        t_unlock();
        t_alarm_wrap();
        t_ctrl_wrap();
        t_time_write();
        t_restart();
        t_status_end();
        t_snapshot();
        t_undef();
        t_relock();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule